// File: doc/BRIEF.md
# Dual Reference Input Selector

This controller decides which of two reference clocks, input 0 or input 1, feeds a clock-translation PLL. It reads a two-bit switching-mode field, a software select bit, a board select pin, a per-input "clock valid" flag, the PLL lock flag, a flag that says the PLL is running as a pure synthesizer, and a flag that says whether the loop runs at low or high bandwidth. It reports three things: the index of the reference in use, an alarm raised when no usable reference drives the loop, and whether that state is a true holdover or a free-run.

There are two manual modes and two automatic modes. In a manual mode the chosen input is fixed by the pin or by the bit, and a dead input raises the alarm. In an automatic mode the bit names a preferred input. The controller locks to it first, then fails over to the other input, enters holdover when both inputs are dead, and recovers either with or without reverting to the preferred input. In synthesizer mode the references are unused, so the selection logic is idle.

All outputs are registered. Each output reflects the inputs sampled at the previous rising clock edge.

Top module: `ref_select_ctl`

## Requirements
- R1: With `sw_mode` = 2'b00 (manual by pin), `active_ref` equals `pin_sel` one clock later; 0 selects input 0 and 1 selects input 1.
- R2: With `sw_mode` = 2'b01 (manual by register), `active_ref` equals `reg_sel` one clock later.
- R3: In either manual mode, `hold_alarm` is set one clock after the selected input's `ref_ok` bit is 0, even if the other input is valid. The selection does not move to the other input. The alarm clears once the selected input is valid again.
- R4: In the automatic modes (`sw_mode` = 2'b10 revertive, 2'b11 non-revertive), the preferred input is `reg_sel` and `pin_sel` has no effect on any output.
- R5: On entering an automatic mode, the controller selects the preferred input. Until `pll_locked` is seen with that input valid, it stays on that input without an alarm while the other input is valid, even if the preferred input is invalid.
- R6: Once locked in an automatic mode, if the current input becomes invalid while the other is valid, `active_ref` moves to the other input one clock later without an alarm.
- R7: In an automatic mode, both `ref_ok` bits at 0 set `hold_alarm` one clock later.
- R8: When leaving an automatic holdover, the controller takes the one input that is valid. If both are valid, it takes the preferred input.
- R9: In revertive mode, running on the non-preferred input with the preferred input valid moves `active_ref` back to the preferred input one clock later.
- R10: In non-revertive mode, the controller stays on the non-preferred input as long as that input is valid, even while the preferred input is valid.
- R11: While `hold_alarm` is 1, exactly one of `hold_keep` (when `low_bw` was 1) and `hold_freerun` (when `low_bw` was 0) is 1. Both are 0 when there is no alarm.
- R12: With `synth_mode` = 1, `hold_alarm` is 0 and `active_ref` follows `reg_sel`, whatever `ref_ok` and `pin_sel` are.
- R13: A change of `sw_mode`, or leaving synthesizer mode, takes effect at the next clock. An automatic mode then re-evaluates starting from the preferred input.
- R14: After reset, `active_ref` is 0 and `hold_alarm`, `hold_keep` and `hold_freerun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_mode | input | 2 | Switching mode: 00 pin, 01 register, 10 auto revertive, 11 auto non-revertive |
| reg_sel | input | 1 | Software select / preferred input |
| pin_sel | input | 1 | Board select pin |
| ref_ok | input | 2 | Per-input clock valid flags, bit i for input i |
| pll_locked | input | 1 | PLL lock flag |
| synth_mode | input | 1 | PLL runs as synthesizer; references unused |
| low_bw | input | 1 | 1 = low-bandwidth loop (holdover), 0 = high-bandwidth (free-run) |
| active_ref | output | 1 | Index of the reference in use |
| hold_alarm | output | 1 | No usable reference |
| hold_keep | output | 1 | Alarm state is a holdover |
| hold_freerun | output | 1 | Alarm state is a free-run |

## Verification
Two events can land in the same clock. The first is a change of switching mode. The second is a failure or return of a reference. The bench provokes this by writing a new `sw_mode` while the current input is alive but the non-preferred input is in use. It judges the result by checking that the new mode re-evaluates from the preferred input rather than keeping the old selection. It also enters an automatic mode with the preferred input dead while the alternate is alive. There, the anti-hunting rule must keep the choice on the preferred input with no alarm. Once both inputs die, it must raise the alarm.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        SW_PIN       = 2'b00,
        SW_REG       = 2'b01,
        SW_AUTO_REV  = 2'b10,
        SW_AUTO_NREV = 2'b11
    } sw_mode_e;

    typedef enum logic [1:0] {
        PH_ACQ  = 2'b00,
        PH_RUN  = 2'b01,
        PH_HOLD = 2'b10
    } phase_e;

    localparam int NUM_REFS = 2;
    localparam int IDX_W    = $clog2(NUM_REFS);

    typedef struct packed {
        phase_e            phase;
        logic [IDX_W-1:0]  cur;
        logic              lowbw;
        logic              synth;
        sw_mode_e          mode;
    } sel_state_t;

endpackage

// File: rtl/refsel_manual.sv
module refsel_manual
    import refsel_pkg::*;
(
    input  logic                 by_pin,
    input  logic                 pin_sel,
    input  logic                 reg_sel,
    input  logic [NUM_REFS-1:0]  ref_ok,
    output logic [IDX_W-1:0]     man_cur,
    output logic                 man_bad
);
    always_comb begin
        man_cur = by_pin ? pin_sel : reg_sel;
        man_bad = ~ref_ok[man_cur];
    end
endmodule

// File: rtl/refsel_auto.sv
module refsel_auto
    import refsel_pkg::*;
(
    input  phase_e               phase_in,
    input  logic [IDX_W-1:0]     cur_in,
    input  logic [IDX_W-1:0]     pref,
    input  logic                 revert,
    input  logic [NUM_REFS-1:0]  ref_ok,
    input  logic                 pll_locked,
    output phase_e               phase_out,
    output logic [IDX_W-1:0]     cur_out
);
    logic [IDX_W-1:0] alt;
    logic [IDX_W-1:0] npref;

    always_comb begin
        alt       = ~cur_in;
        npref     = ~pref;
        phase_out = phase_in;
        cur_out   = cur_in;
        case (phase_in)
            PH_ACQ: begin
                // stay on the starting input until lock; watch the other only for a total loss
                if (!ref_ok[cur_in] && !ref_ok[alt]) begin
                    phase_out = PH_HOLD;
                end else if (ref_ok[cur_in] && pll_locked) begin
                    phase_out = PH_RUN;
                end
            end
            PH_RUN: begin
                if (!ref_ok[cur_in]) begin
                    if (ref_ok[alt]) begin
                        cur_out = alt;
                    end else begin
                        phase_out = PH_HOLD;
                    end
                end else if (revert && (cur_in != pref) && ref_ok[pref]) begin
                    cur_out = pref;
                end
            end
            default: begin
                if (ref_ok[pref]) begin
                    cur_out   = pref;
                    phase_out = PH_RUN;
                end else if (ref_ok[npref]) begin
                    cur_out   = npref;
                    phase_out = PH_RUN;
                end
            end
        endcase
    end
endmodule

// File: rtl/ref_select_ctl.sv
module ref_select_ctl
    import refsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sw_mode,
    input  logic       reg_sel,
    input  logic       pin_sel,
    input  logic [1:0] ref_ok,
    input  logic       pll_locked,
    input  logic       synth_mode,
    input  logic       low_bw,
    output logic       active_ref,
    output logic       hold_alarm,
    output logic       hold_keep,
    output logic       hold_freerun
);
    sel_state_t st_d, st_q;

    sw_mode_e          mode_in;
    logic              is_auto;
    logic              restart;
    phase_e            base_phase;
    logic [IDX_W-1:0]  base_cur;
    logic [IDX_W-1:0]  man_cur;
    logic              man_bad;
    phase_e            auto_phase;
    logic [IDX_W-1:0]  auto_cur;

    assign mode_in = sw_mode_e'(sw_mode);
    assign is_auto = sw_mode[1];
    assign restart = (mode_in != st_q.mode) || st_q.synth;

    assign base_phase = restart ? PH_ACQ : st_q.phase;
    assign base_cur   = restart ? reg_sel : st_q.cur;

    refsel_manual u_manual (
        .by_pin  (mode_in == SW_PIN),
        .pin_sel (pin_sel),
        .reg_sel (reg_sel),
        .ref_ok  (ref_ok),
        .man_cur (man_cur),
        .man_bad (man_bad)
    );

    refsel_auto u_auto (
        .phase_in   (base_phase),
        .cur_in     (base_cur),
        .pref       (reg_sel),
        .revert     (mode_in == SW_AUTO_REV),
        .ref_ok     (ref_ok),
        .pll_locked (pll_locked),
        .phase_out  (auto_phase),
        .cur_out    (auto_cur)
    );

    always_comb begin
        st_d       = st_q;
        st_d.mode  = mode_in;
        st_d.lowbw = low_bw;
        st_d.synth = synth_mode;
        if (synth_mode) begin
            st_d.phase = PH_ACQ;
            st_d.cur   = reg_sel;
        end else if (!is_auto) begin
            st_d.cur   = man_cur;
            st_d.phase = man_bad ? PH_HOLD : PH_ACQ;
        end else begin
            st_d.phase = auto_phase;
            st_d.cur   = auto_cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_ACQ, cur: '0, lowbw: 1'b0, synth: 1'b0, mode: SW_PIN};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_ref   = st_q.cur;
    assign hold_alarm   = (st_q.phase == PH_HOLD);
    assign hold_keep    = hold_alarm & st_q.lowbw;
    assign hold_freerun = hold_alarm & ~st_q.lowbw;

    // R1
    man_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!synth_mode && sw_mode == 2'b00) |=> (active_ref == $past(pin_sel)));

    // R2
    man_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!synth_mode && sw_mode == 2'b01) |=> (active_ref == $past(reg_sel)));

    // R3
    man_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!synth_mode && !sw_mode[1]) |=>
        (hold_alarm == $past(sw_mode[0] ? ~ref_ok[reg_sel] : ~ref_ok[pin_sel])));

    // R7
    auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!synth_mode && sw_mode[1] && ref_ok == 2'b00) |=> hold_alarm);

    // R12
    synth_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        synth_mode |=> (!hold_alarm && active_ref == $past(reg_sel)));

    // R11
    hold_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_alarm |-> (hold_keep == $past(low_bw)) && (hold_freerun == !$past(low_bw)));

    // R6
    failover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!synth_mode && sw_mode[1] && sw_mode == st_q.mode && !st_q.synth &&
         st_q.phase == PH_RUN && !ref_ok[active_ref] && ref_ok[~active_ref])
        |=> (!hold_alarm && active_ref != $past(active_ref)));
endmodule

// File: tb/ref_select_ctl_test.sv
module ref_select_ctl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sw_mode = 2'b00;
    logic       reg_sel = 1'b0;
    logic       pin_sel = 1'b0;
    logic [1:0] ref_ok = 2'b11;
    logic       pll_locked = 1'b0;
    logic       synth_mode = 1'b0;
    logic       low_bw = 1'b0;
    logic       active_ref, hold_alarm, hold_keep, hold_freerun;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ref_select_ctl uut (
        .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode), .reg_sel(reg_sel),
        .pin_sel(pin_sel), .ref_ok(ref_ok), .pll_locked(pll_locked),
        .synth_mode(synth_mode), .low_bw(low_bw), .active_ref(active_ref),
        .hold_alarm(hold_alarm), .hold_keep(hold_keep), .hold_freerun(hold_freerun)
    );

    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    // expected kind flags follow from the alarm and the bandwidth sampled with it
    task automatic expect_out(string req, logic exp_ref, logic exp_alarm, logic bw);
        logic ek, ef;
        ek = exp_alarm & bw;
        ef = exp_alarm & ~bw;
        n_chk++;
        if (active_ref !== exp_ref || hold_alarm !== exp_alarm ||
            hold_keep !== ek || hold_freerun !== ef) begin
            n_bad++;
            $display("FAIL %s: ref/alarm/keep/free actual %b%b%b%b expected %b%b%b%b",
                     req, active_ref, hold_alarm, hold_keep, hold_freerun,
                     exp_ref, exp_alarm, ek, ef);
        end
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step();
        expect_out("R14 reset", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        step();

        // manual modes, full sweep: R1 R2 R3 R11
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int r = 0; r < 2; r++) begin
                    for (int ok = 0; ok < 4; ok++) begin
                        for (int bw = 0; bw < 2; bw++) begin
                            logic sel;
                            sw_mode = m[1:0];
                            pin_sel = p[0];
                            reg_sel = r[0];
                            ref_ok  = ok[1:0];
                            low_bw  = bw[0];
                            step();
                            sel = (m == 1) ? r[0] : p[0];
                            expect_out((m == 1) ? "R2/R3/R11 manual reg" : "R1/R3/R11 manual pin",
                                       sel, ~ok[sel], bw[0]);
                        end
                    end
                end
            end
        end

        // synthesizer mode sweep: R12
        synth_mode = 1'b1;
        sw_mode = 2'b10;
        low_bw = 1'b1;
        for (int ok = 0; ok < 4; ok++) begin
            for (int r = 0; r < 2; r++) begin
                ref_ok  = ok[1:0];
                reg_sel = r[0];
                pin_sel = ~r[0];
                step();
                expect_out("R12 synth idle", r[0], 1'b0, 1'b1);
            end
        end

        // leaving synth into revertive, locked: R13 restart on preferred
        synth_mode = 1'b0;
        reg_sel = 1'b1; ref_ok = 2'b11; pll_locked = 1'b1; pin_sel = 1'b0;
        step();
        expect_out("R13 leave synth", 1'b1, 1'b0, 1'b1);

        // fresh automatic start, unlocked: R5 anti-hunting
        sw_mode = 2'b01; reg_sel = 1'b0; pll_locked = 1'b0;
        step();
        sw_mode = 2'b10;
        step();
        expect_out("R5 start preferred", 1'b0, 1'b0, 1'b1);
        ref_ok = 2'b10;
        step();
        expect_out("R5 ignore alternate", 1'b0, 1'b0, 1'b1);
        step();
        expect_out("R5 still preferred", 1'b0, 1'b0, 1'b1);
        ref_ok = 2'b00;
        step();
        expect_out("R7 both dead while acquiring", 1'b0, 1'b1, 1'b1);
        ref_ok = 2'b11; pll_locked = 1'b1;
        step();
        expect_out("R8 both return take preferred", 1'b0, 1'b0, 1'b1);

        // pin ignored in auto: R4
        pin_sel = 1'b1;
        step();
        expect_out("R4 pin ignored", 1'b0, 1'b0, 1'b1);

        // failover and revert: R6 R9
        ref_ok = 2'b10;
        step();
        expect_out("R6 failover", 1'b1, 1'b0, 1'b1);
        ref_ok = 2'b11;
        step();
        expect_out("R9 revert", 1'b0, 1'b0, 1'b1);

        // non-revertive: R10, holdover kinds R11, recovery R8
        sw_mode = 2'b11;
        step();
        expect_out("R13 enter non-revertive", 1'b0, 1'b0, 1'b1);
        ref_ok = 2'b10;
        step();
        expect_out("R6 failover nrev", 1'b1, 1'b0, 1'b1);
        ref_ok = 2'b11;
        step();
        expect_out("R10 stay alternate", 1'b1, 1'b0, 1'b1);
        step();
        expect_out("R10 stay alternate again", 1'b1, 1'b0, 1'b1);

        // mode change in same cycle as alternate in use: R13
        sw_mode = 2'b10;
        step();
        expect_out("R13 re-evaluate to preferred", 1'b0, 1'b0, 1'b1);
        sw_mode = 2'b11;
        step();
        ref_ok = 2'b10;
        step();
        expect_out("R6 failover again", 1'b1, 1'b0, 1'b1);

        ref_ok = 2'b00; low_bw = 1'b1;
        step();
        expect_out("R7/R11 holdover low bw", 1'b1, 1'b1, 1'b1);
        low_bw = 1'b0;
        step();
        expect_out("R11 free-run high bw", 1'b1, 1'b1, 1'b0);
        ref_ok = 2'b10;
        step();
        expect_out("R8 single valid taken", 1'b1, 1'b0, 1'b0);
        ref_ok = 2'b00;
        step();
        expect_out("R7 hold again", 1'b1, 1'b1, 1'b0);
        ref_ok = 2'b01;
        step();
        expect_out("R8 other single valid", 1'b0, 1'b0, 1'b0);

        // preferred set to input 1 in revertive mode
        sw_mode = 2'b10; reg_sel = 1'b1; ref_ok = 2'b01;
        step();
        expect_out("R5 preferred dead alternate alive", 1'b1, 1'b0, 1'b0);
        ref_ok = 2'b11;
        step();
        ref_ok = 2'b01;
        step();
        expect_out("R6 failover to input 0", 1'b0, 1'b0, 1'b0);
        ref_ok = 2'b11;
        step();
        expect_out("R9 revert to input 1", 1'b1, 1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule